// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns characters written through a small register-style interface into asynchronous serial frames on a single transmit line. It holds one waiting character in a holding buffer while a second character shifts out. A frame carries five to nine data bits, optional even or odd parity and one or two stop bits. An external single-cycle pulse, `bit_tick`, sets the bit period: every bit on the line lasts exactly one tick interval.

Software raises `tx_enable` to claim the pin. The block then asserts `pin_override` so the port logic routes the serial line to the pad instead of general-purpose I/O. Dropping `tx_enable` is a request, not an abort. The override stays asserted, and transmission continues, until the shifter and the holding buffer are both empty.

For nine-bit characters, the top data bit is written first to its own register through `ninth_we`/`ninth_d`. The later low-byte write through `data_we` captures both parts into the buffer as one character. Changing the ninth-bit register after that write does not change the buffered character.

Top module: `usart_tx_core`

## Requirements
- R1: One cycle after `tx_enable` is sampled high, `pin_override` is 1. While `pin_override` is 0, `tx_line` is 1.
- R2: After `tx_enable` falls, `pin_override` stays 1 until the frame being shifted and any buffered character have both been sent. It then falls within two cycles, and `tx_line` is 1.
- R3: A frame is one 0 start bit, then the data bits LSB first, then the parity bit if enabled, then stop bits at 1. `stop_two`=0 gives one stop bit and `stop_two`=1 gives two. Each bit lasts one `bit_tick` interval.
- R4: The character-size code is {`size_hi`,`size_lo`}: 000=5, 001=6, 010=7, 011=8 and 111=9 data bits. Codes 100, 101 and 110 give 8 data bits.
- R5: `par_mode` 10 inserts even parity (bit = XOR of the data bits). 11 inserts odd parity (the inverse of that XOR). 00 and 01 insert no parity bit.
- R6: The ninth data bit sent is the value held in the ninth-bit register when `data_we` was pulsed. Later writes to that register do not change the buffered character.
- R7: `buf_empty` goes to 0 on the clock edge of a `data_we` pulse. It returns to 1 when the character moves into the shifter. That move happens on a `bit_tick` edge when the shifter is idle or is ending its last stop bit, so back-to-back frames have no idle bit between them.
- R8: `tx_done` goes to 1 when a frame's last stop bit ends and no character is buffered. Any `data_we` pulse clears it.
- R9: With `link_mode` other than 00 (01, 10, 11), no new frame starts. A written character stays buffered (`buf_empty`=0) and the line stays high until `link_mode` returns to 00.
- R10: While `rst_n` is low, and right after it rises, `tx_line`=1, `pin_override`=0, `buf_empty`=1 and `tx_done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmitter enable bit (clearing is deferred) |
| link_mode | input | 2 | Link mode; only 00 (asynchronous) transmits |
| par_mode | input | 2 | Parity select: 00/01 none, 10 even, 11 odd |
| stop_two | input | 1 | 1 selects two stop bits |
| size_hi | input | 1 | High bit of the character-size code |
| size_lo | input | 2 | Low bits of the character-size code |
| ninth_we | input | 1 | Write strobe for the ninth-bit register |
| ninth_d | input | 1 | Ninth data bit value |
| data_we | input | 1 | Low data byte write strobe; captures a character |
| data_d | input | LOW_W | Low data byte |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_line | output | 1 | Serial transmit line, idle high |
| pin_override | output | 1 | Tells the port logic to route the serial line |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | Transmit-complete flag |

## Verification
The assertions assume that `data_we` is never pulsed while `buf_empty` is 0. A second write would overwrite the held character, and the scoreboard's expected sequence would no longer hold. They also assume that the format inputs and `link_mode` stay stable while a character is buffered or shifting, because the frame is assembled from those inputs at the moment of transfer. The stimulus keeps within these limits. It waits for `buf_empty` before every further write. It changes size, parity, stop count or link mode only after `tx_done` is seen with nothing outstanding. The single deliberate exception is the stalled-mode test, where the mode is changed with a character held back on purpose.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

   typedef enum logic [1:0] {
      MODE_ASYNC    = 2'b00,
      MODE_CLOCKED  = 2'b01,
      MODE_RESERVED = 2'b10,
      MODE_SPI_HOST = 2'b11
   } link_mode_e;

   typedef enum logic [1:0] {
      PAR_OFF     = 2'b00,
      PAR_OFF_ALT = 2'b01,
      PAR_EVEN    = 2'b10,
      PAR_ODD     = 2'b11
   } parity_sel_e;

   // number of data bits for a 3-bit character-size code
   function automatic logic [3:0] char_bits(input logic [2:0] code);
      case (code)
         3'b000:  char_bits = 4'd5;
         3'b001:  char_bits = 4'd6;
         3'b010:  char_bits = 4'd7;
         3'b111:  char_bits = 4'd9;
         default: char_bits = 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/usart_tx_fmt.sv
module usart_tx_fmt
   import usart_tx_pkg::*;
#(
   parameter int unsigned CHAR_W  = 9,
   parameter int unsigned FRAME_W = 13,
   parameter int unsigned CNT_W   = 4
) (
   input  logic [CHAR_W-1:0]  char_i,
   input  logic [2:0]         size_code,
   input  logic [1:0]         par_mode,
   input  logic               stop_two,
   output logic [FRAME_W-1:0] frame_o,
   output logic [CNT_W-1:0]   len_o
);

   generate
      if (FRAME_W < CHAR_W + 4) begin : g_bad_frame
         $error("usart_tx_fmt: FRAME_W too small for CHAR_W");
      end
      if ((1 << CNT_W) <= FRAME_W) begin : g_bad_cnt
         $error("usart_tx_fmt: CNT_W cannot hold FRAME_W");
      end
   endgenerate

   parity_sel_e       psel;
   logic [3:0]        nbits;
   logic [CHAR_W-1:0] mask;
   logic              par_en;
   logic              par_bit;

   always_comb begin
      psel   = parity_sel_e'(par_mode);
      nbits  = char_bits(size_code);
      for (int i = 0; i < CHAR_W; i++) mask[i] = (i < int'(nbits));
      par_en  = (psel == PAR_EVEN) || (psel == PAR_ODD);
      par_bit = (^(char_i & mask)) ^ (psel == PAR_ODD);
      frame_o    = '1;
      frame_o[0] = 1'b0;
      for (int i = 0; i < CHAR_W; i++)
         if (mask[i]) frame_o[i+1] = char_i[i];
      for (int i = 1; i < FRAME_W; i++)
         if (par_en && (i == int'(nbits) + 1)) frame_o[i] = par_bit;
      len_o = CNT_W'(1) + CNT_W'(nbits) + CNT_W'(par_en)
            + (stop_two ? CNT_W'(2) : CNT_W'(1));
   end

endmodule

// File: rtl/usart_tx_hold.sv
module usart_tx_hold #(
   parameter int unsigned LOW_W   = 8,
   parameter bit          NINE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ninth_we,
   input  logic             ninth_d,
   input  logic             data_we,
   input  logic [LOW_W-1:0] data_d,
   input  logic             take,
   output logic [LOW_W:0]   char_q,
   output logic             full_o
);

   logic ninth_q;

   generate
      if (NINE_EN) begin : g_ninth
         always_ff @(posedge clk) begin
            if (!rst_n)        ninth_q <= 1'b0;
            else if (ninth_we) ninth_q <= ninth_d;
         end
      end else begin : g_no_ninth
         assign ninth_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         char_q <= '0;
         full_o <= 1'b0;
      end else if (data_we) begin
         char_q <= {ninth_q, data_d};
         full_o <= 1'b1;
      end else if (take) begin
         full_o <= 1'b0;
      end
   end

   assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_we |=> full_o);

   assert_take_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full_o);

endmodule

// File: rtl/usart_tx_shift.sv
module usart_tx_shift #(
   parameter int unsigned FRAME_W = 13,
   parameter int unsigned CNT_W   = 4,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               go,
   input  logic               have,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [CNT_W-1:0]   len_i,
   output logic               take_o,
   output logic               busy_o,
   output logic               end_o,
   output logic               line_o
);

   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               last;
   logic               line_c;

   assign last   = busy_o && (cnt_q == CNT_W'(1));
   assign take_o = tick && go && have && (!busy_o || last);
   assign end_o  = tick && last && !take_o;
   assign line_c = busy_o ? sh_q[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '1;
         cnt_q  <= '0;
         busy_o <= 1'b0;
      end else if (take_o) begin
         sh_q   <= frame_i;
         cnt_q  <= len_i;
         busy_o <= 1'b1;
      end else if (tick && busy_o) begin
         sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
         cnt_q <= cnt_q - CNT_W'(1);
         if (last) busy_o <= 1'b0;
      end
   end

   generate
      if (OUT_REG) begin : g_line_reg
         logic line_q;
         always_ff @(posedge clk) begin
            if (!rst_n) line_q <= 1'b1;
            else        line_q <= line_c;
         end
         assign line_o = line_q;
      end else begin : g_line_comb
         assign line_o = line_c;
      end
   endgenerate

   assert_count_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt_q != '0));

   assert_load_only_async_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> go);

   assert_load_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> busy_o);

endmodule

// File: rtl/usart_tx_core.sv
module usart_tx_core
   import usart_tx_pkg::*;
#(
   parameter int unsigned LOW_W   = 8,
   parameter bit          NINE_EN = 1'b1,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_enable,
   input  logic [1:0]       link_mode,
   input  logic [1:0]       par_mode,
   input  logic             stop_two,
   input  logic             size_hi,
   input  logic [1:0]       size_lo,
   input  logic             ninth_we,
   input  logic             ninth_d,
   input  logic             data_we,
   input  logic [LOW_W-1:0] data_d,
   input  logic             bit_tick,
   output logic             tx_line,
   output logic             pin_override,
   output logic             buf_empty,
   output logic             tx_done
);

   localparam int unsigned CHAR_W  = LOW_W + 1;
   localparam int unsigned FRAME_W = CHAR_W + 4;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (LOW_W != 8) begin : g_bad_width
         $error("usart_tx_core: size decode assumes an 8-bit low byte");
      end
   endgenerate

   logic [CHAR_W-1:0]  char_q;
   logic               full;
   logic               take;
   logic               busy;
   logic               frame_end;
   logic               go;
   logic               active_q;
   logic               done_q;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   frame_len;

   assign go = active_q && (link_mode_e'(link_mode) == MODE_ASYNC);

   usart_tx_hold #(.LOW_W(LOW_W), .NINE_EN(NINE_EN)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .ninth_we (ninth_we),
      .ninth_d  (ninth_d),
      .data_we  (data_we),
      .data_d   (data_d),
      .take     (take),
      .char_q   (char_q),
      .full_o   (full)
   );

   usart_tx_fmt #(.CHAR_W(CHAR_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_fmt (
      .char_i    (char_q),
      .size_code ({size_hi, size_lo}),
      .par_mode  (par_mode),
      .stop_two  (stop_two),
      .frame_o   (frame),
      .len_o     (frame_len)
   );

   usart_tx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (bit_tick),
      .go      (go),
      .have    (full),
      .frame_i (frame),
      .len_i   (frame_len),
      .take_o  (take),
      .busy_o  (busy),
      .end_o   (frame_end),
      .line_o  (tx_line)
   );

   // the enable takes effect at once; its release waits for an empty pipe
   always_ff @(posedge clk) begin
      if (!rst_n)         active_q <= 1'b0;
      else if (tx_enable) active_q <= 1'b1;
      else if (!busy && !full) active_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  done_q <= 1'b0;
      else if (data_we)            done_q <= 1'b0;
      else if (frame_end && !full) done_q <= 1'b1;
   end

   assign pin_override = active_q;
   assign buf_empty    = !full;
   assign tx_done      = done_q;

   assert_enable_claims_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_enable |=> pin_override);

   assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_override |-> tx_line);

   assert_hold_while_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_override && !buf_empty) |=> pin_override);

   assert_write_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      data_we |=> !tx_done);

   assert_done_means_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> buf_empty);

endmodule

// File: tb/usart_tx_core_test.sv
module usart_tx_core_test;

   localparam int TICK_DIV = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_enable = 1'b0;
   logic [1:0] link_mode = 2'b00;
   logic [1:0] par_mode = 2'b00;
   logic       stop_two = 1'b0;
   logic       size_hi = 1'b0;
   logic [1:0] size_lo = 2'b11;
   logic       ninth_we = 1'b0;
   logic       ninth_d = 1'b0;
   logic       data_we = 1'b0;
   logic [7:0] data_d = 8'h00;
   logic       bit_tick = 1'b0;
   logic       tx_line;
   logic       pin_override;
   logic       buf_empty;
   logic       tx_done;

   always #5 clk = ~clk;

   usart_tx_core uut (
      .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .link_mode(link_mode),
      .par_mode(par_mode), .stop_two(stop_two), .size_hi(size_hi), .size_lo(size_lo),
      .ninth_we(ninth_we), .ninth_d(ninth_d), .data_we(data_we), .data_d(data_d),
      .bit_tick(bit_tick), .tx_line(tx_line), .pin_override(pin_override),
      .buf_empty(buf_empty), .tx_done(tx_done)
   );

   int checks = 0;
   int errors = 0;
   logic ninth_m = 1'b0;

   logic [15:0] exp_bits[$];
   int          exp_len[$];
   string       exp_tag[$];

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   function automatic void build(input logic [8:0] ch, input logic [2:0] code,
                                 input logic [1:0] pm, input logic two,
                                 output logic [15:0] bits, output int len);
      int nd;
      int idx;
      logic p;
      case (code)
         3'b000: nd = 5;
         3'b001: nd = 6;
         3'b010: nd = 7;
         3'b111: nd = 9;
         default: nd = 8;
      endcase
      bits = '1;
      bits[0] = 1'b0;
      p = 1'b0;
      for (int i = 0; i < nd; i++) begin
         bits[1+i] = ch[i];
         p = p ^ ch[i];
      end
      idx = 1 + nd;
      if (pm == 2'b10 || pm == 2'b11) begin
         bits[idx] = (pm == 2'b11) ? ~p : p;
         idx++;
      end
      len = idx + (two ? 2 : 1);
   endfunction

   // bit clock and scoreboard monitor share one negedge process
   int          tdiv = 0;
   bit          collecting = 0;
   int          rx_n = 0;
   logic [15:0] rx_bits;
   logic [15:0] cur_bits;
   int          cur_len = 0;
   string       cur_tag;
   int          gap_ticks = 0;
   int          last_gap = -1;

   always @(negedge clk) begin
      if (bit_tick && rst_n) begin
         if (collecting) begin
            rx_bits[rx_n] = tx_line;
            rx_n++;
            if (rx_n == cur_len) begin
               logic [15:0] m;
               m = 16'((32'h1 << cur_len) - 1);
               check((rx_bits & m) == (cur_bits & m), cur_tag,
                     int'(rx_bits & m), int'(cur_bits & m));
               collecting = 0;
            end
         end else if (tx_line == 1'b0) begin
            if (exp_bits.size() == 0) begin
               check(0, "R9 frame started with nothing expected", 0, 1);
            end else begin
               cur_bits = exp_bits.pop_front();
               cur_len  = exp_len.pop_front();
               cur_tag  = exp_tag.pop_front();
               rx_bits  = '1;
               rx_bits[0] = 1'b0;
               rx_n = 1;
               collecting = 1;
               last_gap = gap_ticks;
               gap_ticks = 0;
            end
         end else begin
            gap_ticks++;
         end
      end
      if (tdiv == TICK_DIV - 1) begin
         tdiv = 0;
         bit_tick = 1'b1;
      end else begin
         tdiv++;
         bit_tick = 1'b0;
      end
   end

   task automatic send(input logic [7:0] b, input string tag);
      logic [15:0] fb;
      int fl;
      build({ninth_m, b}, {size_hi, size_lo}, par_mode, stop_two, fb, fl);
      exp_bits.push_back(fb);
      exp_len.push_back(fl);
      exp_tag.push_back(tag);
      @(negedge clk);
      data_d = b;
      data_we = 1'b1;
      @(negedge clk);
      data_we = 1'b0;
   endtask

   task automatic set_ninth(input logic v);
      @(negedge clk);
      ninth_d = v;
      ninth_we = 1'b1;
      ninth_m = v;
      @(negedge clk);
      ninth_we = 1'b0;
   endtask

   task automatic wait_empty(input string tag);
      int n = 0;
      while (!buf_empty && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(buf_empty == 1'b1, tag, int'(buf_empty), 1);
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (!(tx_done && exp_bits.size() == 0 && !collecting) && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check(tx_done == 1'b1, tag, int'(tx_done), 1);
      repeat (2) @(negedge clk);
   endtask

   task automatic set_fmt(input logic [2:0] code, input logic [1:0] pm, input logic two);
      @(negedge clk);
      {size_hi, size_lo} = code;
      par_mode = pm;
      stop_two = two;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: outputs while held in reset
      check(tx_line == 1'b1, "R10 line in reset", int'(tx_line), 1);
      check(pin_override == 1'b0, "R10 override in reset", int'(pin_override), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_line == 1'b1, "R10 line after reset", int'(tx_line), 1);
      check(pin_override == 1'b0, "R10 override after reset", int'(pin_override), 0);
      check(buf_empty == 1'b1, "R10 buffer empty after reset", int'(buf_empty), 1);
      check(tx_done == 1'b0, "R10 done after reset", int'(tx_done), 0);

      // R1: enable claims the pin next cycle
      tx_enable = 1'b1;
      @(negedge clk);
      check(pin_override == 1'b1, "R1 override after enable", int'(pin_override), 1);
      check(tx_line == 1'b1, "R1 line idle high", int'(tx_line), 1);

      // R3 / R4: plain 8-bit frame, one stop bit
      set_fmt(3'b011, 2'b00, 1'b0);
      send(8'h5A, "R3 8N1 frame 0x5A");
      check(buf_empty == 1'b0, "R7 write fills buffer", int'(buf_empty), 0);
      wait_done("R8 done after single frame");

      // R7 / R8: transfer, then back-to-back frames without gap
      send(8'h33, "R7 first of pair");
      check(tx_done == 1'b0, "R8 write clears done", int'(tx_done), 0);
      wait_empty("R7 buffer empties on transfer");
      check(tx_line == 1'b0, "R7 start bit with transfer", int'(tx_line), 0);
      send(8'hC4, "R7 second of pair");
      check(buf_empty == 1'b0, "R7 second write fills buffer", int'(buf_empty), 0);
      wait_done("R8 done after pair");
      check(last_gap == 0, "R7 no idle bit between frames", last_gap, 0);
      check(buf_empty == 1'b1, "R8 buffer empty with done", int'(buf_empty), 1);

      // R5 / R4: parity variants and sizes
      set_fmt(3'b000, 2'b10, 1'b0);
      send(8'h1B, "R5 even parity 5 bits 0x1B");
      wait_empty("R5 transfer");
      send(8'h07, "R5 even parity 5 bits 0x07");
      wait_done("R5 done even");
      set_fmt(3'b010, 2'b11, 1'b0);
      send(8'h55, "R5 odd parity 7 bits 0x55");
      wait_done("R5 done odd");
      set_fmt(3'b001, 2'b01, 1'b0);
      send(8'hE9, "R5 code 01 no parity 6 bits");
      wait_done("R5 done code 01");
      set_fmt(3'b101, 2'b00, 1'b0);
      send(8'h81, "R4 code 101 gives 8 bits");
      wait_done("R4 done code 101");

      // R3: two stop bits
      set_fmt(3'b011, 2'b00, 1'b1);
      send(8'h3C, "R3 two stop bits 0x3C");
      wait_empty("R3 transfer");
      send(8'hA7, "R3 two stop bits 0xA7");
      wait_done("R3 done two stop");

      // R6: ninth bit latched at the low-byte write
      set_fmt(3'b111, 2'b10, 1'b0);
      set_ninth(1'b1);
      send(8'h0F, "R6 ninth bit 1 latched");
      set_ninth(1'b0);
      wait_empty("R6 transfer");
      send(8'h80, "R6 ninth bit 0");
      wait_done("R6 done nine bit");

      // R9: non-asynchronous mode holds the character back
      set_fmt(3'b011, 2'b00, 1'b0);
      @(negedge clk);
      link_mode = 2'b10;
      send(8'h99, "R9 frame after mode restored");
      begin
         int lows = 0;
         for (int i = 0; i < 20 * TICK_DIV; i++) begin
            @(negedge clk);
            if (!tx_line) lows++;
         end
         check(lows == 0, "R9 line stays high in mode 10", lows, 0);
         check(buf_empty == 1'b0, "R9 character stays buffered", int'(buf_empty), 0);
      end
      @(negedge clk);
      link_mode = 2'b00;
      wait_done("R9 done after restore");

      // R2: deferred disable with one frame shifting and one buffered
      send(8'h11, "R2 first frame after disable");
      wait_empty("R2 first transfer");
      send(8'h22, "R2 buffered frame after disable");
      @(negedge clk);
      tx_enable = 1'b0;
      begin
         int drops = 0;
         int n = 0;
         while (!(tx_done && exp_bits.size() == 0 && !collecting) && n < 5000) begin
            @(negedge clk);
            n++;
            if (!tx_done && !pin_override) drops++;
         end
         check(drops == 0, "R2 override held while pending", drops, 0);
         check(tx_done == 1'b1, "R2 both frames sent", int'(tx_done), 1);
      end
      repeat (2) @(negedge clk);
      check(pin_override == 1'b0, "R2 override released", int'(pin_override), 0);
      check(tx_line == 1'b1, "R2 line high after release", int'(tx_line), 1);

      repeat (2 * TICK_DIV) @(negedge clk);
      check(exp_bits.size() == 0 && !collecting, "R3 all expected frames seen",
            exp_bits.size(), 0);
      finish_run();
   end

endmodule